// File: doc/BRIEF.md
# Endian-Aware Load/Store Alignment Unit

This unit sits between the memory stage of a 32-bit pipeline and a data memory that is one word wide. A request carries a byte address, an access size, a store-or-load flag, a sign-extension flag, store data and a per-request endianness select. For a store, the unit places the value into the physical byte lanes that the address and the endianness pick, and raises a write strobe with a byte-enable mask. For a load, it takes the memory word that arrives with the request. It selects the addressed bytes, brings them down to bit 0, and sign- or zero-extends them into a registered 32-bit result.

Every access must sit on a boundary equal to its own size. A request that breaks this rule is still accepted, but nothing is written and no load result is produced. A fault flag pulses for one cycle instead. Physical lane k of the memory word holds bits 8k+7..8k. In little-endian mode, address offset o lives in lane o. In big-endian mode, offset o lives in lane 3-o. A word therefore reaches memory unchanged in both modes, and only sub-word placement differs.

The request side is a valid/ready stream and so is the result side. Requests are accepted when `req_valid` and `req_ready` are both high. `req_ready` is low only while a load result is held with `rsp_ready` low. While it is low, the requester must keep the request and the read data stable. A held result keeps `rsp_data` stable until it is taken.

Top module: `lsu_align_unit`

## Requirements
- R1: Size encoding is 00 byte, 01 halfword, 10 word, 11 reserved. A halfword with address bit 0 set is misaligned, and so is a word with address bits 1:0 not 00. The reserved size is always treated as misaligned. A byte access is never misaligned.
- R2: An accepted misaligned request drives `mem_we` low, `mem_be` to 0000 and `mem_wdata` to zero. `fault` is high in the one cycle after acceptance and low otherwise. A misaligned load never raises `rsp_valid`.
- R3: When `req_big` is 0 (little-endian), address offset o maps to lane o. The least significant byte of a halfword or word goes to the lowest-addressed byte.
- R4: When `req_big` is 1 (big-endian), address offset o maps to lane 3-o. The most significant byte of a halfword or word goes to the lowest-addressed byte. A word 0x01234567 stored at 0x100 puts 01 at 0x100 and 67 at 0x103, giving `mem_wdata` 0x01234567.
- R5: An aligned accepted store raises `mem_we`. It sets exactly one, two or four bits of `mem_be` (bit k = lane k) for byte, halfword or word. The value's low-order bytes are placed in those lanes, and all other lanes of `mem_wdata` are zero.
- R6: An aligned load returns the addressed bytes right-justified in `rsp_data`. When `req_sext` is 1, the upper bits copy the value's top bit. When it is 0, they are zero. A word load ignores `req_sext`.
- R7: `rsp_valid` rises in the cycle after an aligned load is accepted. It holds that load's result and falls after a cycle with `rsp_ready` high and no new load.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data` is unchanged. No store is written in that state.
- R9: `mem_addr` is the word address, which is the request address without its two low bits.
- R10: Synchronous active-high reset clears `rsp_valid`, `rsp_data` and `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 reserved |
| req_sext | input | 1 | Load sign-extends when 1 |
| req_big | input | 1 | 1 big-endian, 0 little-endian |
| req_wdata | input | 32 | Store value, right-justified |
| mem_rdata | input | 32 | Memory word for the current load |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_we | output | 1 | Write strobe |
| mem_be | output | 4 | Byte enables, bit k = lane k |
| mem_wdata | output | 32 | Lane-positioned store data |
| rsp_valid | output | 1 | Load result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_data | output | 32 | Extended load result |
| fault | output | 1 | Alignment fault pulse |

## Verification
A wrong lane offset or a wrong endianness choice shows up at once on `mem_be` and `mem_wdata`, in the cycle the store is presented. The same fault shows on `rsp_data` one edge after a load is accepted, as bytes in the wrong place or the wrong extension bits. A misaligned-decode error shows either as a write strobe in the same cycle or as a missing or spurious `fault` pulse on the next edge. A fault in the hold logic of the result register shows while the consumer stalls: `rsp_data` changes or `req_ready` stays high.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int DATA_W = 32;
  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = $clog2(NB);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_lane_calc.sv
module lsu_lane_calc
  import lsu_align_pkg::*;
(
  input  logic [LANE_W-1:0] offset,
  input  acc_size_e         size,
  input  logic              big,
  output logic [NB-1:0]     vmask,
  output logic [LANE_W:0]   nbytes,
  output logic [LANE_W-1:0] shift,
  output logic              misaligned
);
  logic [LANE_W:0] be_shift;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin vmask = 4'b0001; nbytes = 3'd1; misaligned = 1'b0; end
      SZ_HALF: begin vmask = 4'b0011; nbytes = 3'd2; misaligned = offset[0]; end
      SZ_WORD: begin vmask = 4'b1111; nbytes = 3'd4; misaligned = |offset; end
      default: begin vmask = 4'b0000; nbytes = 3'd0; misaligned = 1'b1; end
    endcase
    be_shift = 3'(NB) - nbytes - {1'b0, offset};
    shift    = big ? be_shift[LANE_W-1:0] : offset;
  end
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
  import lsu_align_pkg::*;
(
  input  logic [DATA_W-1:0] wdata,
  input  logic [NB-1:0]     vmask,
  input  logic [LANE_W-1:0] shift,
  input  logic              enable,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] lanes
);
  logic [DATA_W-1:0] masked;
  logic [NB-1:0]     be_raw;

  for (genvar k = 0; k < NB; k++) begin : g_mask
    assign masked[8*k +: 8] = vmask[k] ? wdata[8*k +: 8] : 8'h00;
  end

  assign be_raw = vmask << shift;
  assign be     = enable ? be_raw : '0;
  assign lanes  = enable ? (masked << (8 * shift)) : '0;
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANE_W-1:0] shift,
  input  logic [LANE_W:0]   nbytes,
  input  logic              sext,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] down;
  logic              top_bit;

  assign down = rdata >> (8 * shift);

  always_comb begin
    unique case (nbytes)
      3'd1:    top_bit = down[7];
      3'd2:    top_bit = down[15];
      default: top_bit = down[31];
    endcase
  end

  for (genvar j = 0; j < NB; j++) begin : g_byte
    assign value[8*j +: 8] = (j < int'(nbytes)) ? down[8*j +: 8]
                           : {8{sext & top_bit}};
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_sext,
  input  logic              req_big,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-3:0] mem_addr,
  output logic              mem_we,
  output logic [NB-1:0]     mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fault
);
  logic [NB-1:0]     vmask;
  logic [LANE_W:0]   nbytes;
  logic [LANE_W-1:0] shift;
  logic              misaligned;
  logic              accept;
  logic              load_ok;
  logic [DATA_W-1:0] ld_value;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              fault_q;

  lsu_lane_calc u_calc (
    .offset     (req_addr[LANE_W-1:0]),
    .size       (acc_size_e'(req_size)),
    .big        (req_big),
    .vmask      (vmask),
    .nbytes     (nbytes),
    .shift      (shift),
    .misaligned (misaligned)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign mem_we    = accept && req_store && !misaligned;
  assign load_ok   = accept && !req_store && !misaligned;
  assign mem_addr  = req_addr[ADDR_W-1:LANE_W];

  lsu_store_path u_store (
    .wdata  (req_wdata),
    .vmask  (vmask),
    .shift  (shift),
    .enable (mem_we),
    .be     (mem_be),
    .lanes  (mem_wdata)
  );

  lsu_load_extract u_load (
    .rdata  (mem_rdata),
    .shift  (shift),
    .nbytes (nbytes),
    .sext   (req_sext),
    .value  (ld_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      fault_q     <= 1'b0;
    end else begin
      fault_q <= accept && misaligned;
      if (load_ok) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= ld_value;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign fault     = fault_q;

  // R2: a misaligned request never writes
  assert_fault_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && misaligned) |-> (!mem_we && mem_be == '0 && mem_wdata == '0));

  // R2: a fault pulse never coexists with a load result
  assert_fault_no_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    fault |-> !rsp_valid);

  // R5: enable count matches the access size
  assert_be_count_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($countones(mem_be) == int'(nbytes)));

  // R7: a result only appears after an aligned load was taken
  assert_rsp_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(accept && !req_store && !misaligned));

  // R8: a stalled result stays put
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/lsu_align_unit_tb.sv
module lsu_align_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_store, req_sext, req_big, rsp_ready;
  logic [31:0] req_addr, req_wdata, mem_rdata;
  logic [1:0]  req_size;
  logic        req_ready, mem_we, rsp_valid, fault;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lsu_align_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_addr(req_addr), .req_size(req_size),
    .req_sext(req_sext), .req_big(req_big), .req_wdata(req_wdata),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .fault(fault)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int size_bytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
  endfunction

  function automatic bit is_bad(input logic [1:0] s, input int o);
    return (s == 2'd3) || (s == 2'd1 && (o % 2) != 0) || (s == 2'd2 && o != 0);
  endfunction

  // lane holding the byte at address offset a
  function automatic int lane_of(input int a, input bit big);
    return big ? 3 - a : a;
  endfunction

  task automatic run_case(input bit st, input logic [1:0] sz, input int o,
                          input bit big, input bit sx, input logic [31:0] pat);
    int n;
    bit bad;
    logic [31:0] e_wd, e_ld;
    logic [3:0]  e_be;
    n   = size_bytes(sz);
    bad = is_bad(sz, o);
    e_wd = '0; e_be = '0; e_ld = '0;
    if (!bad) begin
      for (int i = 0; i < n; i++) begin
        int ln, sig;
        ln  = lane_of(o + i, big);
        sig = big ? n - 1 - i : i;
        e_be[ln] = 1'b1;
        e_wd[8*ln +: 8] = pat[8*sig +: 8];
        e_ld[8*sig +: 8] = pat[8*ln +: 8];
      end
      if (sx && n < 4 && e_ld[8*n-1])
        for (int b = 8*n; b < 32; b++) e_ld[b] = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_big = big;
    req_sext = sx; req_addr = 32'h0000_0100 | o; req_wdata = pat;
    mem_rdata = pat;
    #1;
    check(mem_addr == 30'h40, "R9 word address", {2'b0, mem_addr}, 32'h40);
    if (st) begin
      check(mem_we == (!bad), bad ? "R2 no write on fault" : "R5 write strobe",
            {31'b0, mem_we}, {31'b0, !bad});
      check(mem_be == e_be, big ? "R4 byte enables" : "R3 byte enables",
            {28'b0, mem_be}, {28'b0, e_be});
      check(mem_wdata == e_wd, bad ? "R2 data zero" : "R5 lane data",
            mem_wdata, e_wd);
    end else begin
      check(mem_we == 1'b0 && mem_be == 4'b0, "R5 no write on load",
            {27'b0, mem_we, mem_be}, 32'h0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(fault == bad, "R1 R2 fault pulse", {31'b0, fault}, {31'b0, bad});
    if (!st) begin
      check(rsp_valid == !bad, "R7 result valid", {31'b0, rsp_valid}, {31'b0, !bad});
      if (!bad)
        check(rsp_data == e_ld, big ? "R4 R6 load value" : "R3 R6 load value",
              rsp_data, e_ld);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [2];
    pats[0] = 32'h0123_4567;
    pats[1] = 32'hF0A5_C38E;
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
    req_sext = 1'b0; req_big = 1'b0; req_addr = '0; req_wdata = '0;
    mem_rdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(rsp_valid == 1'b0, "R10 reset valid", {31'b0, rsp_valid}, 32'h0);
    check(fault == 1'b0, "R10 reset fault", {31'b0, fault}, 32'h0);
    check(rsp_data == 32'h0, "R10 reset data", rsp_data, 32'h0);
    check(req_ready == 1'b1, "R8 ready after reset", {31'b0, req_ready}, 32'h1);

    // doc-style word example, both modes (R4, R3)
    run_case(1'b1, 2'd2, 0, 1'b1, 1'b0, 32'h0123_4567);
    run_case(1'b1, 2'd2, 0, 1'b0, 1'b0, 32'h0123_4567);

    // sweep: all offsets, sizes, modes, sign flag, load/store, two patterns
    for (int p = 0; p < 2; p++)
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 4; sz++)
          for (int o = 0; o < 4; o++)
            for (int bg = 0; bg < 2; bg++)
              for (int sx = 0; sx < 2; sx++)
                run_case(st[0], sz[1:0], o, bg[0], sx[0], pats[p]);

    // R8 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_store = 1'b0; req_size = 2'd2; req_big = 1'b0;
    req_sext = 1'b0; req_addr = 32'h200; mem_rdata = 32'hCAFE_0001;
    @(negedge clk);
    check(rsp_valid == 1'b1, "R8 result held valid", {31'b0, rsp_valid}, 32'h1);
    check(req_ready == 1'b0, "R8 ready low on stall", {31'b0, req_ready}, 32'h0);
    req_store = 1'b1; req_wdata = 32'h1111_2222;
    #1;
    check(mem_we == 1'b0, "R8 store blocked on stall", {31'b0, mem_we}, 32'h0);
    req_store = 1'b0; mem_rdata = 32'hBEEF_0002;
    @(negedge clk);
    check(rsp_data == 32'hCAFE_0001, "R8 data stable", rsp_data, 32'hCAFE_0001);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_data == 32'hBEEF_0002, "R7 next load taken", rsp_data, 32'hBEEF_0002);
    check(rsp_valid == 1'b1, "R7 next valid", {31'b0, rsp_valid}, 32'h1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7 valid drops", {31'b0, rsp_valid}, 32'h0);

    // R10 reset clears a pending result
    req_valid = 1'b1; req_store = 1'b0; req_addr = 32'h204; mem_rdata = 32'h5;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(rsp_valid == 1'b0 && rsp_data == 32'h0, "R10 reset mid-stall",
          rsp_data, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule